// File: doc/BRIEF.md
# Framed Serial Configuration Port

This block takes 48-bit configuration words from a three-wire serial port: a data line, a bit clock and a framing strobe. The port lines and the two sensor syncs are sampled in the system clock domain. Edges are found by comparing each input with its value one clock earlier. A word starts when the strobe falls. Each rising edge of the bit clock shifts one data bit in, least significant bit first. The word is examined when the strobe rises again.

An accepted word must carry an 8-bit chip code in its lowest bits. A 2-bit category then sends it to one of two shadow banks: the control bank or the shutter bank. The category can also discard it.

Shadow fields reach the decoded outputs at different moments:
- The drive mode and the video standard move at the falling edge of the field sync.
- The other control fields and all shutter fields move at the falling edge of the line sync, but only on a readout line.
- The power-state field acts at once, at the strobe's rising edge.

A hold input from the shutter controller can freeze the sync-timed transfers.

Top module: `sensor_cfg_port`

## Requirements
- R1: The bit on `ser_dat` is shifted in at each rising edge of `ser_clk` while a word is open. Bit D00 arrives first and D47 last. A word opens when `ser_stb` falls and closes when it rises. It is used only if exactly 48 bit-clock rising edges arrived in between; 47 or 49 discard it.
- R2: A word is discarded unless D07..D00 hold the code 8'h81, that is D00=1, D01..D06=0 and D07=1.
- R3: Category D09:D08 routes an accepted word. 00 loads the control shadow, 01 loads the shutter shadow, and 10 or 11 leave every register and output unchanged.
- R4: The control fields drive mode (D12:D10, output `drv_mode`) and video standard (D17, output `vid_std`) reach the outputs at a falling edge of `field_sync`, and at no other time.
- R5: Some fields reach the outputs at a falling edge of `line_sync` when `readout_line` is high. From the control word these are D13 `shut_en`, D14 `rdout_ctl`, D32 `wide_clamp`, D33 `exp_sel`, D35:D34 `clamp_pat` and D37:D36 `adc_phase`. From the shutter word these are D19:D10 `shut_vcnt`, D31:D20 `shut_hcnt` and D41:D32 `shut_vpos`. A `line_sync` fall while `readout_line` is low moves nothing.
- R6: The power field D39:D38 of an accepted control word sets `pwr_state` at the strobe rise, without waiting for a sync edge and regardless of `load_hold`. If D38=0 the state is 0 (run). D39:D38=01 gives 1 (sleep) and 11 gives 2 (halt).
- R7: Control and shutter words may both be sent before one commit edge, and each keeps its own values. A later word of the same category replaces the earlier one in the shadow.
- R8: While `load_hold` is high, sync edges move nothing from shadow to output. After release, the held values move at the next qualifying edge, not at the release itself.
- R9: After reset every output is zero, except `adc_phase`, which is 1 (90 degrees).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_dat | input | 1 | Serial data |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_stb | input | 1 | Frame strobe, low while a word is sent |
| line_sync | input | 1 | Line sync, active falling edge |
| field_sync | input | 1 | Field sync, active falling edge |
| readout_line | input | 1 | High during the readout line |
| load_hold | input | 1 | Blocks sync-timed transfers while high |
| drv_mode | output | 3 | Active drive mode |
| vid_std | output | 1 | Active video standard select |
| shut_en | output | 1 | Electronic shutter enable |
| rdout_ctl | output | 1 | Readout pulse control |
| wide_clamp | output | 1 | Wide black-clamp enable |
| exp_sel | output | 1 | Line-ID / exposure output select |
| clamp_pat | output | 2 | Black-clamp pattern |
| adc_phase | output | 2 | ADC clock phase in steps of 90 degrees |
| pwr_state | output | 2 | 0 run, 1 sleep, 2 halt |
| shut_vcnt | output | 10 | Shutter field count |
| shut_hcnt | output | 12 | Shutter line count |
| shut_vpos | output | 10 | High-speed shutter field position |

## Verification
A wrong bit count or a wrong chip-code test shows up the same way: `pwr_state` changes, or fails to change, in the clock right after the strobe rises. Those are the earliest visible results of a decision to accept or reject a word. A shadow-bank fault is hidden until a later commit edge. It then appears one clock after the `line_sync` or `field_sync` fall, as a wrong field on the group of outputs for that edge. A field routed to the wrong commit group shows as an output that moves at the wrong edge. Timing checks of each group against each edge type catch it within one edge.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int WORD_W = 48;
  localparam logic [7:0] CHIP_ID = 8'h81;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_SLEEP = 2'd1,
    PWR_HALT  = 2'd2
  } pwr_e;

  // fields committed at the field-sync fall
  typedef struct packed {
    logic [2:0] drv_mode;
    logic       vid_std;
  } field_grp_t;

  // control fields committed at the readout-line sync fall
  typedef struct packed {
    logic       shut_en;
    logic       rdout_ctl;
    logic       wide_clamp;
    logic       exp_sel;
    logic [1:0] clamp_pat;
    logic [1:0] adc_phase;
  } line_grp_t;

  // shutter fields, also committed at the readout-line sync fall
  typedef struct packed {
    logic [9:0]  vcnt;
    logic [11:0] hcnt;
    logic [9:0]  vpos;
  } shut_grp_t;

  localparam field_grp_t FIELD_RST = '{drv_mode: 3'd0, vid_std: 1'b0};
  localparam line_grp_t  LINE_RST  = '{shut_en: 1'b0, rdout_ctl: 1'b0,
                                       wide_clamp: 1'b0, exp_sel: 1'b0,
                                       clamp_pat: 2'd0, adc_phase: 2'd1};
  localparam shut_grp_t  SHUT_RST  = '{vcnt: 10'd0, hcnt: 12'd0, vpos: 10'd0};

  function automatic pwr_e fn_pwr(input logic [1:0] code);
    if (!code[0])     return PWR_RUN;
    else if (code[1]) return PWR_HALT;
    else              return PWR_SLEEP;
  endfunction

  function automatic field_grp_t fn_field(input logic [WORD_W-1:0] w);
    field_grp_t f;
    f.drv_mode = w[12:10];
    f.vid_std  = w[17];
    return f;
  endfunction

  function automatic line_grp_t fn_line(input logic [WORD_W-1:0] w);
    line_grp_t l;
    l.shut_en    = w[13];
    l.rdout_ctl  = w[14];
    l.wide_clamp = w[32];
    l.exp_sel    = w[33];
    l.clamp_pat  = w[35:34];
    l.adc_phase  = w[37:36];
    return l;
  endfunction

  function automatic shut_grp_t fn_shut(input logic [WORD_W-1:0] w);
    shut_grp_t s;
    s.vcnt = w[19:10];
    s.hcnt = w[31:20];
    s.vpos = w[41:32];
    return s;
  endfunction

endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  // idle level of every line is high, so reset to ones
  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '1;
    else        prev <= din;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_edge
      assign rise[g] = din[g] & ~prev[g];
      assign fall[g] = ~din[g] & prev[g];
    end
  endgenerate
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_port_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat,
  input  logic             sck_rise,
  input  logic             stb_fall,
  input  logic             stb_rise,
  output logic [WIDTH-1:0] word,
  output logic             word_ok
);
  localparam int CNT_W = $clog2(WIDTH + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(WIDTH + 1);

  logic [WIDTH-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic             open_q;
  logic             chip_match;
  logic             len_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      open_q <= 1'b0;
    end else if (stb_fall) begin
      cnt    <= '0;
      open_q <= 1'b1;
    end else if (stb_rise) begin
      open_q <= 1'b0;
    end else if (open_q && sck_rise) begin
      if (cnt < FULL) sr <= {dat, sr[WIDTH-1:1]};
      cnt <= (cnt == CAP) ? CAP : cnt + 1'b1;
    end
  end

  assign chip_match = (sr[7:0] == CHIP_ID);
  assign len_match  = (cnt == FULL);
  assign word_ok    = stb_rise & open_q & len_match & chip_match;
  assign word       = sr;

  assert_cnt_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
  assert_cnt_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise || stb_fall) |=> $stable(cnt));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              word_ok,
  input  logic              line_fall,
  input  logic              field_fall,
  input  logic              readout,
  input  logic              hold,
  output field_grp_t        act_field,
  output line_grp_t         act_line,
  output shut_grp_t         act_shut,
  output pwr_e              pwr
);
  field_grp_t sh_field;
  line_grp_t  sh_line;
  shut_grp_t  sh_shut;
  logic       ctrl_load, shut_load, line_go, field_go;
  logic       unused_bits;

  assign ctrl_load   = word_ok && (word[9:8] == 2'b00);
  assign shut_load   = word_ok && (word[9:8] == 2'b01);
  assign line_go     = line_fall & readout & ~hold;
  assign field_go    = field_fall & ~hold;
  assign unused_bits = ^{word[47:42], word[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_field <= FIELD_RST;
      sh_line  <= LINE_RST;
      sh_shut  <= SHUT_RST;
      pwr      <= PWR_RUN;
    end else begin
      if (ctrl_load) begin
        sh_field <= fn_field(word);
        sh_line  <= fn_line(word);
        pwr      <= fn_pwr(word[39:38]);
      end
      if (shut_load) sh_shut <= fn_shut(word);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_field <= FIELD_RST;
      act_line  <= LINE_RST;
      act_shut  <= SHUT_RST;
    end else begin
      if (field_go) act_field <= sh_field;
      if (line_go) begin
        act_line <= sh_line;
        act_shut <= sh_shut;
      end
    end
  end

  assert_ctrl_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_ok |=> $stable(sh_line) && $stable(sh_field) && $stable(sh_shut));
  assert_field_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !field_fall |=> $stable(act_field));
  assert_line_readout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !readout |=> $stable(act_line) && $stable(act_shut));
  assert_pwr_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_ok |=> $stable(pwr));
  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(act_field) && $stable(act_line) && $stable(act_shut));
endmodule

// File: rtl/sensor_cfg_port.sv
module sensor_cfg_port
  import cfg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_dat,
  input  logic        ser_clk,
  input  logic        ser_stb,
  input  logic        line_sync,
  input  logic        field_sync,
  input  logic        readout_line,
  input  logic        load_hold,
  output logic [2:0]  drv_mode,
  output logic        vid_std,
  output logic        shut_en,
  output logic        rdout_ctl,
  output logic        wide_clamp,
  output logic        exp_sel,
  output logic [1:0]  clamp_pat,
  output logic [1:0]  adc_phase,
  output logic [1:0]  pwr_state,
  output logic [9:0]  shut_vcnt,
  output logic [11:0] shut_hcnt,
  output logic [9:0]  shut_vpos
);
  localparam int NEDGE = 4;
  localparam int E_SCK = 3, E_STB = 2, E_LINE = 1, E_FIELD = 0;

  logic [NEDGE-1:0]  rise, fall;
  logic [WORD_W-1:0] word;
  logic              word_ok;
  logic              unused_edges;
  field_grp_t        act_field;
  line_grp_t         act_line;
  shut_grp_t         act_shut;
  pwr_e              pwr;

  cfg_edge_det #(.W(NEDGE)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_clk, ser_stb, line_sync, field_sync}),
    .rise (rise),
    .fall (fall)
  );

  assign unused_edges = ^{fall[E_SCK], rise[E_LINE], rise[E_FIELD]};

  cfg_serial_rx #(.WIDTH(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .dat     (ser_dat),
    .sck_rise(rise[E_SCK]),
    .stb_fall(fall[E_STB]),
    .stb_rise(rise[E_STB]),
    .word    (word),
    .word_ok (word_ok)
  );

  cfg_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .word      (word),
    .word_ok   (word_ok),
    .line_fall (fall[E_LINE]),
    .field_fall(fall[E_FIELD]),
    .readout   (readout_line),
    .hold      (load_hold),
    .act_field (act_field),
    .act_line  (act_line),
    .act_shut  (act_shut),
    .pwr       (pwr)
  );

  assign drv_mode   = act_field.drv_mode;
  assign vid_std    = act_field.vid_std;
  assign shut_en    = act_line.shut_en;
  assign rdout_ctl  = act_line.rdout_ctl;
  assign wide_clamp = act_line.wide_clamp;
  assign exp_sel    = act_line.exp_sel;
  assign clamp_pat  = act_line.clamp_pat;
  assign adc_phase  = act_line.adc_phase;
  assign pwr_state  = pwr;
  assign shut_vcnt  = act_shut.vcnt;
  assign shut_hcnt  = act_shut.hcnt;
  assign shut_vpos  = act_shut.vpos;
endmodule

// File: tb/sensor_cfg_port_test.sv
module sensor_cfg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_dat = 1'b0, ser_clk = 1'b0, ser_stb = 1'b1;
  logic line_sync = 1'b1, field_sync = 1'b1, readout_line = 1'b0, load_hold = 1'b0;
  logic [2:0]  drv_mode;
  logic        vid_std, shut_en, rdout_ctl, wide_clamp, exp_sel;
  logic [1:0]  clamp_pat, adc_phase, pwr_state;
  logic [9:0]  shut_vcnt, shut_vpos;
  logic [11:0] shut_hcnt;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sensor_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
    .ser_stb(ser_stb), .line_sync(line_sync), .field_sync(field_sync),
    .readout_line(readout_line), .load_hold(load_hold),
    .drv_mode(drv_mode), .vid_std(vid_std), .shut_en(shut_en),
    .rdout_ctl(rdout_ctl), .wide_clamp(wide_clamp), .exp_sel(exp_sel),
    .clamp_pat(clamp_pat), .adc_phase(adc_phase), .pwr_state(pwr_state),
    .shut_vcnt(shut_vcnt), .shut_hcnt(shut_hcnt), .shut_vpos(shut_vpos)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_ctrl(input logic [7:0] chip, input logic [1:0] cat,
      input logic [2:0] mode, input logic smd, input logic std, input logic wide,
      input logic [1:0] pat, input logic [1:0] adc, input logic [1:0] stb);
    logic [47:0] w = '0;
    w[7:0] = chip; w[9:8] = cat; w[12:10] = mode; w[13] = smd; w[17] = std;
    w[32] = wide; w[35:34] = pat; w[37:36] = adc; w[39:38] = stb;
    return w;
  endfunction

  function automatic logic [47:0] mk_shut(input logic [9:0] vc, input logic [11:0] hc,
      input logic [9:0] vp);
    logic [47:0] w = '0;
    w[7:0] = 8'h81; w[9:8] = 2'b01; w[19:10] = vc; w[31:20] = hc; w[41:32] = vp;
    return w;
  endfunction

  task automatic send(input logic [47:0] w, input int nclk);
    @(negedge clk) ser_stb = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      ser_dat = (i < 48) ? w[i] : 1'b0;
      ser_clk = 1'b1;
      @(negedge clk) ser_clk = 1'b0;
      @(negedge clk);
    end
    ser_stb = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_line(input logic rd);
    @(negedge clk) begin readout_line = rd; line_sync = 1'b0; end
    @(negedge clk) line_sync = 1'b1;
    @(negedge clk) readout_line = 1'b0;
  endtask

  task automatic pulse_field();
    @(negedge clk) field_sync = 1'b0;
    @(negedge clk) field_sync = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 drv_mode", drv_mode, 0);
    chk("R9 adc_phase", adc_phase, 1);
    chk("R9 pwr_state", pwr_state, 0);
    chk("R9 clamp/shut", {vid_std, shut_en, rdout_ctl, wide_clamp, exp_sel, clamp_pat}, 0);
    chk("R9 shutter", {shut_vcnt, shut_hcnt, shut_vpos}, 0);
  endtask

  task automatic t_edges();
    send(mk_ctrl(8'h81, 2'b00, 3'd5, 1'b1, 1'b1, 1'b1, 2'd2, 2'd3, 2'b00), 48);
    chk("R4 mode before edge", drv_mode, 0);
    pulse_line(1'b0);
    chk("R5 non-readout line ignored", adc_phase, 1);
    pulse_line(1'b1);
    chk("R5 adc_phase", adc_phase, 3);
    chk("R5 clamp_pat", clamp_pat, 2);
    chk("R5 shut_en/wide", {shut_en, wide_clamp}, 2'b11);
    chk("R4 mode not on line edge", drv_mode, 0);
    pulse_field();
    chk("R4 drv_mode", drv_mode, 5);
    chk("R4 vid_std", vid_std, 1);
  endtask

  task automatic t_chip();
    send(mk_ctrl(8'h80, 2'b00, 3'd2, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'b11), 48);
    chk("R2 bad chip pwr", pwr_state, 0);
    pulse_line(1'b1);
    pulse_field();
    chk("R2 bad chip mode", drv_mode, 5);
    chk("R2 bad chip adc", adc_phase, 3);
  endtask

  task automatic t_length();
    logic [47:0] w = mk_ctrl(8'h81, 2'b00, 3'd3, 1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 2'b01);
    send(w, 47);
    chk("R1 47 clocks pwr", pwr_state, 0);
    send(w, 49);
    chk("R1 49 clocks pwr", pwr_state, 0);
    pulse_line(1'b1);
    pulse_field();
    chk("R1 short/long word mode", drv_mode, 5);
    chk("R1 short/long word adc", adc_phase, 3);
    send(w, 48);
    chk("R1 48 clocks pwr", pwr_state, 1);
    pulse_line(1'b1);
    pulse_field();
    chk("R1 48 clocks mode", drv_mode, 3);
    chk("R1 48 clocks adc", adc_phase, 2);
  endtask

  task automatic t_category();
    send(mk_shut(10'h2A5, 12'h9C3, 10'h155), 48);
    chk("R3 shutter before edge", shut_vcnt, 0);
    pulse_line(1'b1);
    chk("R3 shut_vcnt", shut_vcnt, 10'h2A5);
    chk("R3 shut_hcnt", shut_hcnt, 12'h9C3);
    chk("R3 shut_vpos", shut_vpos, 10'h155);
    chk("R3 control untouched by shutter word", {drv_mode, adc_phase, pwr_state}, {3'd3, 2'd2, 2'd1});
    send(mk_ctrl(8'h81, 2'b10, 3'd7, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 2'b11), 48);
    chk("R3 test category pwr", pwr_state, 1);
    pulse_line(1'b1);
    pulse_field();
    chk("R3 test category ctrl", {drv_mode, adc_phase, clamp_pat}, {3'd3, 2'd2, 2'd2});
    chk("R3 test category shutter", {shut_vcnt, shut_hcnt, shut_vpos}, {10'h2A5, 12'h9C3, 10'h155});
  endtask

  task automatic t_overwrite();
    send(mk_shut(10'h001, 12'h002, 10'h003), 48);
    send(mk_ctrl(8'h81, 2'b00, 3'd1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 2'b11), 48);
    send(mk_shut(10'h3FF, 12'hFFF, 10'h000), 48);
    chk("R6 halt immediate", pwr_state, 2);
    pulse_line(1'b1);
    pulse_field();
    chk("R7 second shutter word wins", {shut_vcnt, shut_hcnt, shut_vpos}, {10'h3FF, 12'hFFF, 10'h000});
    chk("R7 control kept alongside", {drv_mode, adc_phase}, {3'd1, 2'd1});
  endtask

  task automatic t_standby();
    load_hold = 1'b1;
    send(mk_ctrl(8'h81, 2'b00, 3'd1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 2'b01), 48);
    chk("R6 sleep under hold", pwr_state, 1);
    send(mk_ctrl(8'h81, 2'b00, 3'd1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 2'b11), 48);
    chk("R6 halt code 11", pwr_state, 2);
    send(mk_ctrl(8'h81, 2'b00, 3'd1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 2'b10), 48);
    chk("R6 code 10 is run", pwr_state, 0);
    load_hold = 1'b0;
  endtask

  task automatic t_hold();
    load_hold = 1'b1;
    send(mk_ctrl(8'h81, 2'b00, 3'd6, 1'b1, 1'b0, 1'b1, 2'd2, 2'd0, 2'b00), 48);
    send(mk_shut(10'h011, 12'h022, 10'h033), 48);
    pulse_line(1'b1);
    pulse_field();
    chk("R8 held ctrl", {drv_mode, vid_std, adc_phase}, {3'd1, 1'b1, 2'd1});
    chk("R8 held shutter", shut_vcnt, 10'h3FF);
    @(negedge clk) load_hold = 1'b0;
    @(negedge clk);
    chk("R8 release alone moves nothing", {drv_mode, adc_phase, shut_vcnt}, {3'd1, 2'd1, 10'h3FF});
    pulse_line(1'b1);
    chk("R8 line after release", {adc_phase, shut_vcnt, shut_hcnt}, {2'd0, 10'h011, 12'h022});
    chk("R8 mode waits for field", drv_mode, 1);
    pulse_field();
    chk("R8 field after release", {drv_mode, vid_std}, {3'd6, 1'b0});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edges();
    t_chip();
    t_length();
    t_category();
    t_overwrite();
    t_standby();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule